// File: doc/BRIEF.md
# Exception Detection and Vector Selector

This block sits next to the decode stage of a small 32-bit processor and decides, one instruction slot at a time, whether an exception has to be started. It looks at the opword being decoded, a decoded "stop" indication with its immediate status-register value, the live trace bit and a hardware breakpoint trigger. When one of these calls for an exception, it produces a single-cycle request with an 8-bit vector number. It also says which PC the frame builder should stack (the current opword or the one after it) and whether the exception may alter the status register's mask and master bits.

Four sources are recognised. Two unimplemented opcode groups are selected by the top nibble of the opword. A breakpoint-driven debug interrupt uses a vector fixed inside the block, with no acknowledge cycle, and leaves the mask and master bits alone. A stop whose immediate turns trace on while trace is off first loads the status register with that immediate and then takes a trace exception that points past the stop.

Only one exception is handled at a time. When several sources are active together, the lower-priority ones are dropped rather than queued. No request is issued while the downstream frame builder reports busy.

Top module: `exc_vector_sel`

## Requirements
- R1: With `op_valid` high and opword bits 15..12 equal to 4'b1010, the block raises a request one clock later with vector 10, `pc_sel_next`=0 (stack the faulting opword) and `sr_mask_upd`=1.
- R2: With `op_valid` high and opword bits 15..12 equal to 4'b1111, the block raises a request one clock later with vector 11, `pc_sel_next`=0 and `sr_mask_upd`=1.
- R3: `bkpt_trig` high raises a request one clock later with vector 12, `pc_sel_next`=0 and `sr_mask_upd`=0. The mask and master bits must not change, and `op_valid` does not gate this source.
- R4: With `op_valid` and `stop_dec` high, `sr_trace` low and bit 15 (the trace bit) of `stop_imm` set, the block raises a request one clock later with vector 9, `pc_sel_next`=1, `sr_mask_upd`=1, `sr_load`=1 and `sr_load_val` equal to `stop_imm`.
- R5: A stop raises no request when `sr_trace` is already high or when bit 15 of `stop_imm` is clear.
- R6: When several sources are active in the same cycle, the debug interrupt wins over line-A/line-F, and line-A/line-F win over trace-after-stop. Only the winner is reported, and the losers are discarded.
- R7: The opword and the stop inputs have no effect while `op_valid` is low.
- R8: No request is issued in the clock after a cycle in which `frame_busy` is high, and requests presented during that cycle are discarded.
- R9: `exc_req` is a one-cycle pulse: it is never high in two consecutive cycles, even when a source stays active.
- R10: During reset, and in any cycle without a request, `exc_req`, `exc_vec`, `pc_sel_next`, `sr_mask_upd`, `sr_load` and `sr_load_val` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Opword and stop inputs are valid this cycle |
| opword | input | 16 | Opword in decode |
| stop_dec | input | 1 | Decoded opword is a stop instruction |
| stop_imm | input | 16 | Immediate status-register value of the stop |
| sr_trace | input | 1 | Current trace bit of the status register |
| bkpt_trig | input | 1 | Hardware breakpoint trigger |
| frame_busy | input | 1 | Frame builder busy; holds requests off |
| exc_req | output | 1 | One-cycle exception request |
| exc_vec | output | 8 | Vector number of the request |
| pc_sel_next | output | 1 | 1: stack next-instruction PC, 0: current PC |
| sr_mask_upd | output | 1 | Mask and master bits may be changed |
| sr_load | output | 1 | Load status register from `sr_load_val` first |
| sr_load_val | output | 16 | Value to load into the status register |

## Verification
The breakpoint trigger is not qualified by `op_valid`, so it can coincide with a line-A/line-F opword or with a trace-setting stop in the same cycle. Equally, a line-F opword can carry a stop indication. The bench drives these overlaps on purpose, and random stimulus adds more. A behavioural model picks the winner from the priority order and checks every output field on every clock. In particular, it checks that a debug win clears `sr_load` and `sr_mask_upd`, and that a losing source does not reappear on the following cycle.

// File: rtl/exc_pkg.sv
package exc_pkg;
  localparam int VEC_W = 8;

  localparam logic [VEC_W-1:0] VEC_NONE   = 8'd0;
  localparam logic [VEC_W-1:0] VEC_TRACE  = 8'd9;
  localparam logic [VEC_W-1:0] VEC_LINE_A = 8'd10;
  localparam logic [VEC_W-1:0] VEC_LINE_F = 8'd11;
  localparam logic [VEC_W-1:0] VEC_DEBUG  = 8'd12;

  typedef enum logic [2:0] {
    SRC_NONE   = 3'd0,
    SRC_TRACE  = 3'd1,
    SRC_LINE_A = 3'd2,
    SRC_LINE_F = 3'd3,
    SRC_DEBUG  = 3'd4
  } exc_src_e;

  function automatic logic [VEC_W-1:0] src_vector(input exc_src_e s);
    case (s)
      SRC_TRACE:  return VEC_TRACE;
      SRC_LINE_A: return VEC_LINE_A;
      SRC_LINE_F: return VEC_LINE_F;
      SRC_DEBUG:  return VEC_DEBUG;
      default:    return VEC_NONE;
    endcase
  endfunction

  // Debug interrupt keeps mask/master bits; every other source may change them.
  function automatic logic src_touches_mask(input exc_src_e s);
    return (s != SRC_NONE) && (s != SRC_DEBUG);
  endfunction

  // Only the trace-after-stop case stacks the address past the instruction.
  function automatic logic src_stacks_next(input exc_src_e s);
    return s == SRC_TRACE;
  endfunction
endpackage

// File: rtl/exc_opdecode.sv
module exc_opdecode #(
  parameter int OP_W = 16,
  parameter int GRP_W = 4,
  parameter logic [GRP_W-1:0] LINE_A_CODE = 4'b1010,
  parameter logic [GRP_W-1:0] LINE_F_CODE = 4'b1111
) (
  input  logic            op_valid,
  input  logic [GRP_W-1:0] op_group,
  output logic            hit_line_a,
  output logic            hit_line_f
);
  localparam int NUM_GRP = 2;
  localparam logic [NUM_GRP*GRP_W-1:0] CODES = {LINE_F_CODE, LINE_A_CODE};

  logic [NUM_GRP-1:0] hit;

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
    assign hit[g] = op_valid && (op_group == CODES[g*GRP_W +: GRP_W]);
  end

  assign hit_line_a = hit[0];
  assign hit_line_f = hit[1];
endmodule

// File: rtl/exc_stop_trace.sv
module exc_stop_trace #(
  parameter int SR_W = 16,
  parameter int T_BIT = 15
) (
  input  logic            op_valid,
  input  logic            stop_dec,
  input  logic            sr_trace,
  input  logic [SR_W-1:0] stop_imm,
  output logic            trace_after_stop
);
  assign trace_after_stop = op_valid && stop_dec && !sr_trace && stop_imm[T_BIT];
endmodule

// File: rtl/exc_arbiter.sv
module exc_arbiter
  import exc_pkg::*;
(
  input  logic     req_debug,
  input  logic     req_line_a,
  input  logic     req_line_f,
  input  logic     req_trace,
  output exc_src_e winner
);
  always_comb begin
    if (req_debug)       winner = SRC_DEBUG;
    else if (req_line_a) winner = SRC_LINE_A;
    else if (req_line_f) winner = SRC_LINE_F;
    else if (req_trace)  winner = SRC_TRACE;
    else                 winner = SRC_NONE;
  end
endmodule

// File: rtl/exc_vector_sel.sv
module exc_vector_sel
  import exc_pkg::*;
#(
  parameter int OP_W = 16,
  parameter int SR_W = 16,
  parameter int T_BIT = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             op_valid,
  input  logic [OP_W-1:0]  opword,
  input  logic             stop_dec,
  input  logic [SR_W-1:0]  stop_imm,
  input  logic             sr_trace,
  input  logic             bkpt_trig,
  input  logic             frame_busy,
  output logic             exc_req,
  output logic [VEC_W-1:0] exc_vec,
  output logic             pc_sel_next,
  output logic             sr_mask_upd,
  output logic             sr_load,
  output logic [SR_W-1:0]  sr_load_val
);
  localparam int GRP_W = 4;

  // Named internal events
  logic     ev_line_a;
  logic     ev_line_f;
  logic     ev_trace_stop;
  exc_src_e win_src;
  logic     may_issue;
  exc_src_e issue_src;

  logic unused_low;
  assign unused_low = ^opword[OP_W-GRP_W-1:0];

  exc_opdecode #(.OP_W(OP_W), .GRP_W(GRP_W)) u_dec (
    .op_valid   (op_valid),
    .op_group   (opword[OP_W-1 -: GRP_W]),
    .hit_line_a (ev_line_a),
    .hit_line_f (ev_line_f)
  );

  exc_stop_trace #(.SR_W(SR_W), .T_BIT(T_BIT)) u_stop (
    .op_valid         (op_valid),
    .stop_dec         (stop_dec),
    .sr_trace         (sr_trace),
    .stop_imm         (stop_imm),
    .trace_after_stop (ev_trace_stop)
  );

  exc_arbiter u_arb (
    .req_debug  (bkpt_trig),
    .req_line_a (ev_line_a),
    .req_line_f (ev_line_f),
    .req_trace  (ev_trace_stop),
    .winner     (win_src)
  );

  // No queuing: anything not issued this cycle is dropped.
  assign may_issue = !frame_busy && !exc_req;
  assign issue_src = may_issue ? win_src : SRC_NONE;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      exc_req     <= 1'b0;
      exc_vec     <= VEC_NONE;
      pc_sel_next <= 1'b0;
      sr_mask_upd <= 1'b0;
      sr_load     <= 1'b0;
      sr_load_val <= '0;
    end else begin
      exc_req     <= issue_src != SRC_NONE;
      exc_vec     <= src_vector(issue_src);
      pc_sel_next <= src_stacks_next(issue_src);
      sr_mask_upd <= src_touches_mask(issue_src);
      sr_load     <= issue_src == SRC_TRACE;
      sr_load_val <= (issue_src == SRC_TRACE) ? stop_imm : '0;
    end
  end
endmodule

// File: rtl/exc_vector_sel_chk.sv
module exc_vector_sel_chk
  import exc_pkg::*;
#(
  parameter int OP_W = 16,
  parameter int SR_W = 16,
  parameter int T_BIT = 15
) (
  input logic             clk,
  input logic             rst_n,
  input logic             op_valid,
  input logic [OP_W-1:0]  opword,
  input logic             stop_dec,
  input logic [SR_W-1:0]  stop_imm,
  input logic             sr_trace,
  input logic             bkpt_trig,
  input logic             frame_busy,
  input logic             exc_req,
  input logic [VEC_W-1:0] exc_vec,
  input logic             pc_sel_next,
  input logic             sr_mask_upd,
  input logic             sr_load,
  input logic [SR_W-1:0]  sr_load_val
);
  logic free_slot;
  assign free_slot = !frame_busy && !exc_req;

  a_r1_line_a: assert property (@(posedge clk) disable iff (!rst_n)
    (free_slot && !bkpt_trig && op_valid && opword[OP_W-1 -: 4] == 4'b1010)
    |=> (exc_req && exc_vec == 8'd10 && !pc_sel_next && sr_mask_upd));

  a_r2_line_f: assert property (@(posedge clk) disable iff (!rst_n)
    (free_slot && !bkpt_trig && op_valid && opword[OP_W-1 -: 4] == 4'b1111)
    |=> (exc_req && exc_vec == 8'd11 && !pc_sel_next && sr_mask_upd));

  a_r3_debug_keeps_mask: assert property (@(posedge clk) disable iff (!rst_n)
    (free_slot && bkpt_trig) |=> (exc_req && exc_vec == 8'd12 && !sr_mask_upd && !sr_load));

  a_r4_stop_trace: assert property (@(posedge clk) disable iff (!rst_n)
    sr_load |-> (exc_req && exc_vec == 8'd9 && pc_sel_next && sr_load_val[T_BIT]));

  a_r4_load_value: assert property (@(posedge clk) disable iff (!rst_n)
    (free_slot && !bkpt_trig && op_valid && stop_dec && !sr_trace && stop_imm[T_BIT]
     && opword[OP_W-1 -: 4] != 4'b1010 && opword[OP_W-1 -: 4] != 4'b1111)
    |=> (sr_load && sr_load_val == $past(stop_imm)));

  a_r8_busy_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    frame_busy |=> !exc_req);

  a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    exc_req |=> !exc_req);

  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !exc_req |-> (exc_vec == 8'd0 && !pc_sel_next && !sr_mask_upd && !sr_load && sr_load_val == '0));
endmodule

bind exc_vector_sel exc_vector_sel_chk #(.OP_W(OP_W), .SR_W(SR_W), .T_BIT(T_BIT)) chk_i (.*);

// File: tb/exc_vector_sel_tb.sv
module exc_vector_sel_tb_top;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_n;
  logic        op_valid;
  logic [15:0] opword;
  logic        stop_dec;
  logic [15:0] stop_imm;
  logic        sr_trace;
  logic        bkpt_trig;
  logic        frame_busy;
  logic        exc_req;
  logic [7:0]  exc_vec;
  logic        pc_sel_next;
  logic        sr_mask_upd;
  logic        sr_load;
  logic [15:0] sr_load_val;

  exc_vector_sel dut_i (.*);

  int total = 0;
  int bad = 0;
  bit finished = 0;

  // expected outputs after the coming edge
  int e_req = 0, e_vec = 0, e_pcn = 0, e_msk = 0, e_ld = 0, e_ldv = 0;

  task automatic chk(string tag, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // Behavioural model: picks a winner from the priority list and applies the gating.
  task automatic model_step();
    int vec = 0, pcn = 0, msk = 0, ld = 0, ldv = 0;
    int nib;
    nib = int'(opword[15:12]);
    if (bkpt_trig) vec = 12;
    else if (op_valid && nib == 10) begin vec = 10; msk = 1; end
    else if (op_valid && nib == 15) begin vec = 11; msk = 1; end
    else if (op_valid && stop_dec && !sr_trace && stop_imm[15]) begin
      vec = 9; pcn = 1; msk = 1; ld = 1; ldv = int'(stop_imm);
    end
    if (!rst_n || frame_busy || e_req == 1 || vec == 0) begin
      e_req = 0; e_vec = 0; e_pcn = 0; e_msk = 0; e_ld = 0; e_ldv = 0;
    end else begin
      e_req = 1; e_vec = vec; e_pcn = pcn; e_msk = msk; e_ld = ld; e_ldv = ldv;
    end
  endtask

  task automatic cyc(string tag);
    model_step();
    @(posedge clk);
    @(negedge clk);
    chk(tag, "exc_req", int'(exc_req), e_req);
    chk(tag, "exc_vec", int'(exc_vec), e_vec);
    chk(tag, "pc_sel_next", int'(pc_sel_next), e_pcn);
    chk(tag, "sr_mask_upd", int'(sr_mask_upd), e_msk);
    chk(tag, "sr_load", int'(sr_load), e_ld);
    chk(tag, "sr_load_val", int'(sr_load_val), e_ldv);
  endtask

  task automatic idle();
    op_valid = 0; opword = 16'h4E71; stop_dec = 0; stop_imm = 16'h2700;
    sr_trace = 0; bkpt_trig = 0; frame_busy = 0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    idle();
    rst_n = 0;
    @(negedge clk);
    cyc("R10_reset"); cyc("R10_reset");
    opword = 16'hA123; op_valid = 1; bkpt_trig = 1;
    cyc("R10_reset_held");
    idle(); rst_n = 1;
    cyc("R10_idle");

    opword = 16'hA000; op_valid = 1; cyc("R1_line_a"); idle(); cyc("R1_gap");
    opword = 16'hF2A5; op_valid = 1; cyc("R2_line_f"); idle(); cyc("R2_gap");
    bkpt_trig = 1; cyc("R3_debug"); idle(); cyc("R3_gap");
    op_valid = 1; stop_dec = 1; stop_imm = 16'hA714; opword = 16'h4E72;
    cyc("R4_stop_trace"); idle(); cyc("R4_gap");
    op_valid = 1; stop_dec = 1; stop_imm = 16'h8000; sr_trace = 1; opword = 16'h4E72;
    cyc("R5_trace_on"); idle();
    op_valid = 1; stop_dec = 1; stop_imm = 16'h2700; opword = 16'h4E72;
    cyc("R5_no_t"); idle();
    op_valid = 1; opword = 16'hA00F; bkpt_trig = 1; cyc("R6_dbg_over_a"); idle(); cyc("R6_gap");
    op_valid = 1; opword = 16'hF000; stop_dec = 1; stop_imm = 16'h8000;
    cyc("R6_f_over_trace"); idle(); cyc("R6_loser_dropped");
    op_valid = 1; stop_dec = 1; stop_imm = 16'hFFFF; opword = 16'h4E72; bkpt_trig = 1;
    cyc("R6_dbg_over_trace"); idle(); cyc("R6_gap2");
    op_valid = 0; opword = 16'hAFFF; cyc("R7_invalid_a");
    opword = 16'hF123; cyc("R7_invalid_f");
    stop_dec = 1; stop_imm = 16'h8000; cyc("R7_invalid_stop"); idle();
    bkpt_trig = 1; op_valid = 0; cyc("R3_no_valid_gate"); idle(); cyc("R3_gap2");
    frame_busy = 1; op_valid = 1; opword = 16'hA000; cyc("R8_busy");
    frame_busy = 0; idle(); cyc("R8_dropped");
    op_valid = 1; opword = 16'hF000;
    cyc("R9_first"); cyc("R9_blocked"); cyc("R9_again"); cyc("R9_blocked2");
    idle(); cyc("R10_quiet");

    for (int i = 0; i < 400; i++) begin
      op_valid = 1'($urandom_range(0, 1));
      opword = 16'($urandom);
      stop_dec = ($urandom_range(0, 2) == 0);
      stop_imm = 16'($urandom);
      sr_trace = ($urandom_range(0, 3) == 0);
      bkpt_trig = ($urandom_range(0, 5) == 0);
      frame_busy = ($urandom_range(0, 4) == 0);
      cyc("R6_random");
    end
    idle(); cyc("R10_end");
    finish_run();
  end
endmodule